// File: doc/BRIEF.md
# Non-blocking direct-mapped data cache controller

This block sits between a processor's load/store port and a memory request scheduler. It keeps a direct-mapped array of four-word lines, each with one valid bit and one address tag. Loads that hit are answered on the next cycle. Loads that miss are tracked in a small table of outstanding line reads. Each entry of that table records the line address and, for every word of the line, a waiting flag and the processor tag of the load that asked for it. A second miss to a line that is already outstanding is merged into the existing entry and sends no new read to memory.

Stores always go straight through to memory. A store that hits updates the cached word, and a store that misses leaves the array untouched. A store to a line whose read is still outstanding is held back until that read completes.

When the scheduler returns a line, the tag of the returned line names the table entry. The line is written into the array, the entry is released, and every waiting word is handed back to the processor with its stored tag, one word per cycle in ascending word order. The processor port stalls only for resource or ordering reasons: the outstanding table is full, a word slot is already taken, a store meets a pending read, or a returned line is being drained.

Top module: `nbc_cache`

## Requirements
- R1: After reset every line is invalid and the outstanding table is empty. `cpu_rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are low with no request, and `fill_ready` is high.
- R2: The word address splits into a word offset in bits [1:0], a line index above it and a line tag in the top bits. A load that misses, with its line not outstanding, takes the lowest-numbered free table entry. It raises `mem_rd_valid` with `mem_rd_line` = address bits [AW-1:2] and `mem_rd_tag` = that entry number, and it is accepted only while `mem_rd_ready` is high.
- R3: A load that misses to a line already outstanding, with its word slot free, is accepted without raising `mem_rd_valid`.
- R4: A load whose word slot in the outstanding entry is already taken stalls (`cpu_req_ready` low) until that entry is released.
- R5: A line accepted on the return channel (`fill_valid` and `fill_ready` at a clock edge) is matched to its table entry by `fill_tag`. Every waiting word is returned with its stored processor tag and its word of `fill_data` (word w at bits [w*DW +: DW]). The words come one per cycle in ascending word order, and the first appears on the second cycle after the accepting edge.
- R6: A returned line is written into the array and its table entry is freed at the accepting edge. Later loads to that line hit.
- R7: An accepted load that hits raises `cpu_rsp_valid` in the next cycle with the cached word and its processor tag, also while misses are outstanding.
- R8: Every accepted store raises `mem_wr_valid` with its address and data. A store hit updates the cached word. A store miss allocates nothing, so a later load to that line still misses.
- R9: A store to a line with an outstanding read stalls until that read is returned.
- R10: A load miss to a new line stalls while all table entries are in use, and it is accepted once an entry is freed.
- R11: `cpu_req_ready` is low in the cycle a line is accepted and while returned words are being drained; `fill_ready` is low while draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Store data |
| cpu_req_ptag | input | PTW | Processor tag of the request |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_rsp_valid | output | 1 | Load data returned |
| cpu_rsp_data | output | DW | Returned word |
| cpu_rsp_ptag | output | PTW | Processor tag of the returned word |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Scheduler accepts the line read |
| mem_rd_line | output | AW-2 | Line address to read |
| mem_rd_tag | output | PIW | Table entry number carried with the read |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_ready | input | 1 | Scheduler accepts the write |
| mem_wr_addr | output | AW | Word address written |
| mem_wr_data | output | DW | Word written |
| fill_valid | input | 1 | Returned line present |
| fill_ready | output | 1 | Returned line accepted this cycle when valid |
| fill_tag | input | PIW | Table entry the line belongs to |
| fill_data | input | 4*DW | Returned line, word w at [w*DW +: DW] |

## Verification
The bench builds the block with four lines, a two-entry outstanding table, 10-bit word addresses and 16-bit data. With only two entries, two misses to different lines fill the table, so the full-table stall and the reuse of a freed entry come up within a few requests. With four lines, lines 4 and 12 share index 0, so a returned line can displace a cached one and a store to a third line on that index misses. This lets the bench mix hits, merges, store stalls and drains of one or two words in a short run.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int WPL = 4;
  localparam int WOFS = 2;

  function automatic logic [WOFS-1:0] lowest_word(input logic [WPL-1:0] m);
    logic [WOFS-1:0] r;
    r = '0;
    for (int i = WPL - 1; i >= 0; i--) begin
      if (m[i]) r = WOFS'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/nbc_line_store.sv
module nbc_line_store
  import nbc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IDXW = 4,
  parameter int TAGW = 10
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic [IDXW-1:0]     rd_idx,
  input  logic [WOFS-1:0]     rd_word,
  input  logic [TAGW-1:0]     rd_tag,
  output logic                rd_hit,
  output logic [DW-1:0]       rd_data,
  input  logic                fill_en,
  input  logic [IDXW-1:0]     fill_idx,
  input  logic [TAGW-1:0]     fill_tag,
  input  logic [WPL*DW-1:0]   fill_data,
  input  logic                st_en,
  input  logic [IDXW-1:0]     st_idx,
  input  logic [WOFS-1:0]     st_word,
  input  logic [DW-1:0]       st_data
);
  localparam int LINES = 1 << IDXW;

  logic [LINES-1:0] valid_q, valid_d;
  logic [TAGW-1:0]  tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES][WPL];

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = data_q[rd_idx][rd_word];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      for (int w = 0; w < WPL; w++) data_q[fill_idx][w] <= fill_data[w*DW +: DW];
    end else if (st_en) begin
      data_q[st_idx][st_word] <= st_data;
    end
  end

  // R6: a written line is present with its tag in the following cycle
  assert_fill_installs_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_en |=> valid_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/nbc_prb.sv
module nbc_prb
  import nbc_pkg::*;
#(
  parameter int N   = 4,
  parameter int LAW = 14,
  parameter int PTW = 4,
  localparam int PIW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [LAW-1:0]       look_line,
  input  logic [WOFS-1:0]      look_word,
  input  logic [PTW-1:0]       look_ptag,
  output logic                 match,
  output logic                 match_word_busy,
  output logic                 avail,
  output logic [PIW-1:0]       free_idx,
  input  logic                 alloc_en,
  input  logic                 merge_en,
  input  logic                 rel_en,
  input  logic [PIW-1:0]       rel_idx,
  output logic [LAW-1:0]       rel_line,
  output logic [WPL-1:0]       rel_mask,
  output logic [WPL*PTW-1:0]   rel_ptags
);
  logic [N-1:0]         used_q, used_d;
  logic [LAW-1:0]       line_q [N];
  logic [LAW-1:0]       line_d [N];
  logic [WPL-1:0]       wv_q   [N];
  logic [WPL-1:0]       wv_d   [N];
  logic [WPL*PTW-1:0]   pt_q   [N];
  logic [WPL*PTW-1:0]   pt_d   [N];
  logic [PIW-1:0]       match_idx;

  always_comb begin
    avail    = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        avail    = 1'b1;
        free_idx = PIW'(i);
      end
    end
  end

  always_comb begin
    match     = 1'b0;
    match_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (used_q[i] && (line_q[i] == look_line)) begin
        match     = 1'b1;
        match_idx = PIW'(i);
      end
    end
  end

  assign match_word_busy = match && wv_q[match_idx][look_word];
  assign rel_line  = line_q[rel_idx];
  assign rel_mask  = wv_q[rel_idx];
  assign rel_ptags = pt_q[rel_idx];

  always_comb begin
    used_d = used_q;
    for (int i = 0; i < N; i++) begin
      line_d[i] = line_q[i];
      wv_d[i]   = wv_q[i];
      pt_d[i]   = pt_q[i];
    end
    if (rel_en) begin
      used_d[rel_idx] = 1'b0;
      wv_d[rel_idx]   = '0;
    end
    if (alloc_en) begin
      used_d[free_idx]                            = 1'b1;
      line_d[free_idx]                            = look_line;
      wv_d[free_idx]                              = '0;
      wv_d[free_idx][look_word]                   = 1'b1;
      pt_d[free_idx][int'(look_word)*PTW +: PTW]  = look_ptag;
    end else if (merge_en) begin
      wv_d[match_idx][look_word]                  = 1'b1;
      pt_d[match_idx][int'(look_word)*PTW +: PTW] = look_ptag;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      for (int i = 0; i < N; i++) wv_q[i] <= '0;
    end else begin
      used_q <= used_d;
      for (int i = 0; i < N; i++) wv_q[i] <= wv_d[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      line_q[i] <= line_d[i];
      pt_q[i]   <= pt_d[i];
    end
  end

  // R10: a new entry is taken only when one is free
  assert_alloc_has_room_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc_en |-> avail);
  // R4: a merge never overwrites a waiting word slot
  assert_merge_slot_free_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    merge_en |-> (match && !match_word_busy));
  // R5: a returned line names an entry that is in use
  assert_release_live_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    rel_en |-> used_q[rel_idx]);
  // R6: the released entry is free one cycle later
  assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rel_en && !alloc_en) |=> !used_q[$past(rel_idx)]);
endmodule

// File: rtl/nbc_drain.sv
module nbc_drain
  import nbc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PTW = 4
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                load_en,
  input  logic [WPL*DW-1:0]   load_data,
  input  logic [WPL*PTW-1:0]  load_ptags,
  input  logic [WPL-1:0]      load_mask,
  output logic                busy,
  output logic [DW-1:0]       out_data,
  output logic [PTW-1:0]      out_ptag
);
  logic [WPL-1:0]     mask_q, mask_d;
  logic [WPL*DW-1:0]  data_q;
  logic [WPL*PTW-1:0] ptag_q;
  logic [WOFS-1:0]    sel;

  assign busy     = |mask_q;
  assign sel      = lowest_word(mask_q);
  assign out_data = data_q[int'(sel)*DW +: DW];
  assign out_ptag = ptag_q[int'(sel)*PTW +: PTW];

  always_comb begin
    mask_d = mask_q;
    if (load_en)   mask_d      = load_mask;
    else if (busy) mask_d[sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= load_data;
      ptag_q <= load_ptags;
    end
  end

  // R5: exactly one word leaves per draining cycle
  assert_one_word_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !load_en) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
  // R11: a new line is never loaded over words still waiting
  assert_no_load_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    load_en |-> !busy);
endmodule

// File: rtl/nbc_cache.sv
module nbc_cache
  import nbc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int IDXW  = 4,
  parameter int PRB_N = 4,
  parameter int PTW   = 4,
  localparam int LAW  = AW - WOFS,
  localparam int TAGW = AW - WOFS - IDXW,
  localparam int PIW  = (PRB_N > 1) ? $clog2(PRB_N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  input  logic                cpu_req_store,
  input  logic [AW-1:0]       cpu_req_addr,
  input  logic [DW-1:0]       cpu_req_wdata,
  input  logic [PTW-1:0]      cpu_req_ptag,
  output logic                cpu_req_ready,
  output logic                cpu_rsp_valid,
  output logic [DW-1:0]       cpu_rsp_data,
  output logic [PTW-1:0]      cpu_rsp_ptag,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [LAW-1:0]      mem_rd_line,
  output logic [PIW-1:0]      mem_rd_tag,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [AW-1:0]       mem_wr_addr,
  output logic [DW-1:0]       mem_wr_data,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [PIW-1:0]      fill_tag,
  input  logic [WPL*DW-1:0]   fill_data
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [WOFS-1:0] req_word;
  logic [IDXW-1:0] req_idx;
  logic [TAGW-1:0] req_tag;
  logic [LAW-1:0]  req_line;

  assign req_word = cpu_req_addr[WOFS-1:0];
  assign req_idx  = cpu_req_addr[WOFS +: IDXW];
  assign req_tag  = cpu_req_addr[AW-1 -: TAGW];
  assign req_line = cpu_req_addr[AW-1:WOFS];

  logic            hit;
  logic [DW-1:0]   hit_data;
  logic            prb_match, prb_word_busy, prb_avail;
  logic [PIW-1:0]  prb_free_idx;
  logic [LAW-1:0]  rel_line;
  logic [WPL-1:0]  rel_mask;
  logic [WPL*PTW-1:0] rel_ptags;
  logic            drain_busy;
  logic [DW-1:0]   drain_data;
  logic [PTW-1:0]  drain_ptag;

  logic fill_take, blocked, new_miss, fire;
  logic load_hit_fire, alloc_en, merge_en, store_upd;

  assign fill_ready = !drain_busy;
  assign fill_take  = fill_valid && fill_ready;
  assign blocked    = drain_busy || fill_take;
  assign new_miss   = !cpu_req_store && !hit && !prb_match;

  always_comb begin
    if (blocked)            cpu_req_ready = 1'b0;
    else if (cpu_req_store) cpu_req_ready = !prb_match && mem_wr_ready;
    else                    cpu_req_ready = hit
                                         || (prb_match && !prb_word_busy)
                                         || (!prb_match && prb_avail && mem_rd_ready);
  end

  assign fire          = cpu_req_valid && cpu_req_ready;
  assign load_hit_fire = fire && !cpu_req_store && hit;
  assign alloc_en      = fire && new_miss;
  assign merge_en      = fire && !cpu_req_store && !hit && prb_match;
  assign store_upd     = fire && cpu_req_store && hit;

  assign mem_rd_valid = cpu_req_valid && !blocked && new_miss && prb_avail;
  assign mem_rd_line  = req_line;
  assign mem_rd_tag   = prb_free_idx;
  assign mem_wr_valid = cpu_req_valid && !blocked && cpu_req_store && !prb_match;
  assign mem_wr_addr  = cpu_req_addr;
  assign mem_wr_data  = cpu_req_wdata;

  nbc_line_store #(.DW(DW), .IDXW(IDXW), .TAGW(TAGW)) u_store (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rd_idx    (req_idx),
    .rd_word   (req_word),
    .rd_tag    (req_tag),
    .rd_hit    (hit),
    .rd_data   (hit_data),
    .fill_en   (fill_take),
    .fill_idx  (rel_line[IDXW-1:0]),
    .fill_tag  (rel_line[LAW-1:IDXW]),
    .fill_data (fill_data),
    .st_en     (store_upd),
    .st_idx    (req_idx),
    .st_word   (req_word),
    .st_data   (cpu_req_wdata)
  );

  nbc_prb #(.N(PRB_N), .LAW(LAW), .PTW(PTW)) u_prb (
    .clk             (clk),
    .rst_ni          (rst_ni),
    .look_line       (req_line),
    .look_word       (req_word),
    .look_ptag       (cpu_req_ptag),
    .match           (prb_match),
    .match_word_busy (prb_word_busy),
    .avail           (prb_avail),
    .free_idx        (prb_free_idx),
    .alloc_en        (alloc_en),
    .merge_en        (merge_en),
    .rel_en          (fill_take),
    .rel_idx         (fill_tag),
    .rel_line        (rel_line),
    .rel_mask        (rel_mask),
    .rel_ptags       (rel_ptags)
  );

  nbc_drain #(.DW(DW), .PTW(PTW)) u_drain (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .load_en    (fill_take),
    .load_data  (fill_data),
    .load_ptags (rel_ptags),
    .load_mask  (rel_mask),
    .busy       (drain_busy),
    .out_data   (drain_data),
    .out_ptag   (drain_ptag)
  );

  logic           rsp_valid_d, rsp_en;
  logic [DW-1:0]  rsp_data_d;
  logic [PTW-1:0] rsp_ptag_d;

  always_comb begin
    rsp_valid_d = load_hit_fire || drain_busy;
    rsp_en      = rsp_valid_d;
    rsp_data_d  = load_hit_fire ? hit_data     : drain_data;
    rsp_ptag_d  = load_hit_fire ? cpu_req_ptag : drain_ptag;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cpu_rsp_valid <= 1'b0;
    else         cpu_rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      cpu_rsp_data <= rsp_data_d;
      cpu_rsp_ptag <= rsp_ptag_d;
    end
  end

  // R7: an accepted hit is answered next cycle with its own tag
  assert_hit_answered_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    load_hit_fire |=> (cpu_rsp_valid && (cpu_rsp_ptag == $past(cpu_req_ptag))));
  // R3: a merged miss sends no read to memory
  assert_merge_no_read_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    merge_en |-> !mem_rd_valid);
  // R8: every accepted store is written through
  assert_store_written_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && cpu_req_store) |-> (mem_wr_valid && mem_wr_ready));
  // R9: no store passes a pending read of its line
  assert_store_waits_read_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && cpu_req_store) |-> !prb_match);
  // R11: requests are held off while returned words drain
  assert_hold_while_drain_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    drain_busy |-> !cpu_req_ready);
  // R2: a new miss is accepted only together with its line read
  assert_miss_reads_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc_en |-> (mem_rd_valid && mem_rd_ready));
endmodule

// File: tb/nbc_cache_tb_top.sv
module nbc_cache_tb_top;
  localparam int DW = 16, AW = 10, IDXW = 2, PRB_N = 2, PTW = 4;
  localparam int LAW = AW - 2, PIW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_req_valid = 1'b0, cpu_req_store = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic [PTW-1:0] cpu_req_ptag = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_data;
  logic [PTW-1:0] cpu_rsp_ptag;
  logic mem_rd_valid, mem_wr_valid, fill_ready;
  logic mem_rd_ready = 1'b1, mem_wr_ready = 1'b1, fill_valid = 1'b0;
  logic [LAW-1:0] mem_rd_line;
  logic [PIW-1:0] mem_rd_tag;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic [PIW-1:0] fill_tag = '0;
  logic [4*DW-1:0] fill_data = '0;

  nbc_cache #(.DW(DW), .AW(AW), .IDXW(IDXW), .PRB_N(PRB_N), .PTW(PTW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_store(cpu_req_store),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ptag(cpu_req_ptag), .cpu_req_ready(cpu_req_ready),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .cpu_rsp_ptag(cpu_rsp_ptag),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_line(mem_rd_line), .mem_rd_tag(mem_rd_tag),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_tag(fill_tag), .fill_data(fill_data)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wordval(input int line, input int w);
    return DW'(16'h1000 + line * 4 + w);
  endfunction

  function automatic logic [4*DW-1:0] linedata(input int line);
    logic [4*DW-1:0] d;
    for (int w = 0; w < 4; w++) d[w*DW +: DW] = wordval(line, w);
    return d;
  endfunction

  // captured at acceptance and after it
  logic cap_rd_v, cap_wr_v, cap_rsp_v;
  logic [LAW-1:0] cap_rd_line;
  logic [PIW-1:0] cap_rd_tag;
  logic [AW-1:0] cap_wr_addr;
  logic [DW-1:0] cap_wr_data, cap_rsp_data;
  logic [PTW-1:0] cap_rsp_ptag;

  task automatic send(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [PTW-1:0] pt);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_store = st; cpu_req_addr = a;
    cpu_req_wdata = wd; cpu_req_ptag = pt;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    cap_rd_v = mem_rd_valid; cap_rd_line = mem_rd_line; cap_rd_tag = mem_rd_tag;
    cap_wr_v = mem_wr_valid; cap_wr_addr = mem_wr_addr; cap_wr_data = mem_wr_data;
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    @(negedge clk);
    cap_rsp_v = cpu_rsp_valid; cap_rsp_data = cpu_rsp_data; cap_rsp_ptag = cpu_rsp_ptag;
  endtask

  task automatic expect_stall(input bit st, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_store = st; cpu_req_addr = a; cpu_req_ptag = 4'hF;
    #1;
    chk(!cpu_req_ready, req, 32'(cpu_req_ready), 0);
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [PIW-1:0] t, input int line);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_data = linedata(line);
    #1;
    while (!fill_ready) begin @(negedge clk); #1; end
    chk(!cpu_req_ready, "R11 ready low in fill cycle", 32'(cpu_req_ready), 0);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
    chk(!cpu_req_ready && !fill_ready, "R11 stalled while draining", {cpu_req_ready, fill_ready}, 0);
    chk(!cpu_rsp_valid, "R5 no response in first cycle after fill", 32'(cpu_rsp_valid), 0);
  endtask

  task automatic expect_word(input int line, input int w, input logic [PTW-1:0] pt, input string req);
    @(negedge clk);
    chk(cpu_rsp_valid && cpu_rsp_data == wordval(line, w) && cpu_rsp_ptag == pt, req,
        {cpu_rsp_valid, 11'd0, cpu_rsp_ptag, cpu_rsp_data}, {1'b1, 11'd0, pt, wordval(line, w)});
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    chk(!cpu_rsp_valid, req, 32'(cpu_rsp_valid), 0);
  endtask

  // table: store, addr, wdata, ptag, exp_wr, exp_rsp, exp_data
  typedef struct packed {
    logic st; logic [AW-1:0] a; logic [DW-1:0] wd; logic [PTW-1:0] pt;
    logic ewr; logic ersp; logic [DW-1:0] ed;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h010, 16'h0000, 4'd6,  1'b0, 1'b1, 16'h1010},
    '{1'b0, 10'h011, 16'h0000, 4'd7,  1'b0, 1'b1, 16'h1011},
    '{1'b0, 10'h013, 16'h0000, 4'd8,  1'b0, 1'b1, 16'h1013},
    '{1'b1, 10'h013, 16'hBEEF, 4'd0,  1'b1, 1'b0, 16'h0000},
    '{1'b0, 10'h013, 16'h0000, 4'd9,  1'b0, 1'b1, 16'hBEEF},
    '{1'b1, 10'h041, 16'h5A5A, 4'd0,  1'b1, 1'b0, 16'h0000},
    '{1'b0, 10'h012, 16'h0000, 4'd10, 1'b0, 1'b1, 16'h1012}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!cpu_rsp_valid && !mem_rd_valid && !mem_wr_valid && fill_ready, "R1 reset state",
        {cpu_rsp_valid, mem_rd_valid, mem_wr_valid, fill_ready}, 32'b0001);

    // R2 first miss: line 4, entry 0
    send(0, 10'h010, '0, 4'd1);
    chk(cap_rd_v && cap_rd_line == 8'd4 && cap_rd_tag == 1'b0, "R2 miss read line/tag",
        {cap_rd_v, cap_rd_tag, cap_rd_line}, {1'b1, 1'b0, 8'd4});
    chk(!cap_rsp_v, "R2 no response on miss", 32'(cap_rsp_v), 0);
    // R3 merge
    send(0, 10'h012, '0, 4'd2);
    chk(!cap_rd_v, "R3 merge issues no read", 32'(cap_rd_v), 0);
    expect_stall(0, 10'h010, "R4 same word stalls");
    expect_stall(1, 10'h011, "R9 store to pending line stalls");
    // second entry: line 9
    send(0, 10'h025, '0, 4'd4);
    chk(cap_rd_v && cap_rd_line == 8'd9 && cap_rd_tag == 1'b1, "R2 second entry",
        {cap_rd_v, cap_rd_tag, cap_rd_line}, {1'b1, 1'b1, 8'd9});
    expect_stall(0, 10'h030, "R10 table full stalls");

    // R5 fill line 4: words 0 then 2
    do_fill(1'b0, 4);
    expect_word(4, 0, 4'd1, "R5 first word ascending");
    expect_word(4, 2, 4'd2, "R5 second word ascending");
    expect_idle("R5 drain ends");

    // R10 freed entry reused
    send(0, 10'h030, '0, 4'd5);
    chk(cap_rd_v && cap_rd_tag == 1'b0 && cap_rd_line == 8'd12, "R10 freed entry reused",
        {cap_rd_v, cap_rd_tag, cap_rd_line}, {1'b1, 1'b0, 8'd12});

    // table: hits while two misses are outstanding, stores
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].st, VECS[i].a, VECS[i].wd, VECS[i].pt);
      if (VECS[i].st)
        chk(cap_wr_v && cap_wr_addr == VECS[i].a && cap_wr_data == VECS[i].wd, "R8 write-through",
            {cap_wr_v, 5'd0, cap_wr_addr, cap_wr_data}, {1'b1, 5'd0, VECS[i].a, VECS[i].wd});
      else
        chk(!cap_wr_v && !cap_rd_v, "R7 hit makes no memory request", {cap_wr_v, cap_rd_v}, 0);
      chk(cap_rsp_v == VECS[i].ersp && (!VECS[i].ersp ||
          (cap_rsp_data == VECS[i].ed && cap_rsp_ptag == VECS[i].pt)), "R7 hit response",
          {cap_rsp_v, 11'd0, cap_rsp_ptag, cap_rsp_data}, {VECS[i].ersp, 11'd0, VECS[i].pt, VECS[i].ed});
    end

    do_fill(1'b1, 9);
    expect_word(9, 1, 4'd4, "R5 line 9 word");
    expect_idle("R5 line 9 drain ends");
    do_fill(1'b0, 12);
    expect_word(12, 0, 4'd5, "R5 line 12 word");
    expect_idle("R5 line 12 drain ends");

    send(0, 10'h025, '0, 4'd11);
    chk(cap_rsp_v && cap_rsp_data == wordval(9, 1) && !cap_rd_v, "R6 filled line hits",
        {cap_rsp_v, cap_rd_v, cap_rsp_data}, {1'b1, 1'b0, wordval(9, 1)});
    send(0, 10'h041, '0, 4'd12);
    chk(cap_rd_v && cap_rd_line == 8'd16 && cap_rd_tag == 1'b0, "R8 store miss did not allocate",
        {cap_rd_v, cap_rd_tag, cap_rd_line}, {1'b1, 1'b0, 8'd16});
    mem_rd_ready = 1'b0;
    expect_stall(0, 10'h050, "R2 miss waits for read channel");
    mem_rd_ready = 1'b1;
    do_fill(1'b0, 16);
    expect_word(16, 1, 4'd12, "R5 line 16 word");
    expect_idle("R5 line 16 drain ends");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule